// File: doc/BRIEF.md
# Optical Link Byte Framing Controller

This block connects a processor to the byte-wide side of a serial link coder. It handles both directions. For transmit, the processor loads bytes into a transmit queue and then raises an enable. The link coder asks for one byte per request cycle. If the enable is high and the queue holds a byte, the controller pops that byte and presents it as data. In every other case it presents the comma idle symbol (K28.5) marked as a control symbol, so the line never starves. Lowering the enable stops the queue at the next request, which is the next byte boundary. The bytes still in the queue are kept and are sent once the enable returns.

For receive, every byte strobed in by the decoder and marked as data is written into a receive queue. Bytes marked as control symbols are discarded. The processor reads the receive queue from its head. A level interrupt stays high while the queue holds anything. If a data byte arrives while the receive queue is full, the byte is lost and a sticky overflow flag is set. A processor clear pulse resets the flag.

The byte interface runs at one byte per ten line bits, which is one byte per cycle of the byte clock. Coding, serialisation and optics are outside the block.

Top module: `olink_frame_ctrl`

## Requirements
- R1: Reset state: `enc_data` is 8'hBC, `enc_ctrl` is 1, and `rx_irq`, `rx_ovf` and `tx_full` are 0.
- R2: While `tx_en` is 0, every encoder request yields the idle symbol 8'hBC with `enc_ctrl`=1. No byte is removed from the transmit queue.
- R3: While `tx_en` is 1 and the transmit queue is not empty, each request cycle removes one byte. That byte appears on `enc_data` with `enc_ctrl`=0 after the next clock edge. Bytes come out in write order.
- R4: A request made while the transmit queue is empty yields the idle symbol 8'hBC with `enc_ctrl`=1.
- R5: `enc_data` and `enc_ctrl` hold their values in every cycle that has no request.
- R6: Lowering `tx_en` mid-packet turns the very next request into idle. The remaining bytes stay queued and resume in order once `tx_en` returns to 1.
- R7: A decoder strobe with `dec_ctrl`=0 writes `dec_data` into the receive queue. A strobe with `dec_ctrl`=1 writes nothing.
- R8: `rx_irq` is 1 exactly while the receive queue is not empty. It rises after the clock edge that writes the first byte and falls after the edge that reads the last byte.
- R9: A data byte that arrives while the receive queue is full is dropped and sets `rx_ovf`. `rx_ovf` stays set until an `ovf_clr` pulse. If a set and a clear happen in the same cycle, the set wins.
- R10: A processor write while `tx_full` is 1 is ignored. Exactly the queue depth of bytes is kept.
- R11: The receive queue shows its oldest byte on `cpu_rx_data` and releases it on `cpu_rx_rd`. A read while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_tx_wr | input | 1 | Processor writes one byte to the transmit queue |
| cpu_tx_data | input | 8 | Byte to queue for transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_en | input | 1 | Transmit enable set by the processor after loading |
| enc_rd_req | input | 1 | Encoder request for the next byte |
| enc_data | output | 8 | Byte to the encoder |
| enc_ctrl | output | 1 | 1 = control (idle) symbol, 0 = payload |
| dec_strobe | input | 1 | Decoder has a byte this cycle |
| dec_data | input | 8 | Decoded byte |
| dec_ctrl | input | 1 | Decoded byte is a control symbol |
| cpu_rx_rd | input | 1 | Processor pops the receive head |
| cpu_rx_data | output | 8 | Oldest received byte |
| rx_irq | output | 1 | Level interrupt, receive queue not empty |
| rx_ovf | output | 1 | Sticky receive overflow |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The bench builds the block with an eight-entry transmit queue and a four-entry receive queue. These sizes let a few writes reach the full condition on both sides. That brings the ignored ninth transmit write, the dropped receive byte, and the same-cycle overflow set-and-clear into short directed runs. The small sizes also make the pointers wrap during the drain that follows each fill.

// File: rtl/olink_pkg.sv
// Shared constants and types for the optical link framing controller.
// Assumes byte-wide link coder interface.
package olink_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] K28_5 = 8'hBC;
    typedef logic [BYTE_W-1:0] oct_t;
endpackage

// File: rtl/olink_byte_fifo.sv
// Synchronous queue with head visible at the output (first word fall-through).
// Assumes: push when full and pop when empty are ignored; depth is a power of two.
module olink_byte_fifo #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         do_push, do_pop;

    // Status from pointer comparison (extra wrap bit).
    always_comb begin
        empty   = (wp == rp);
        full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rp[AW-1:0]];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp[AW-1:0]] <= din;
    end

    // Pointer advance with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/olink_tx_sched.sv
// Transmit scheduler: on each encoder request, picks a queued byte or the idle symbol.
// Assumes the queue head is valid whenever empty is low; outputs hold between requests.
module olink_tx_sched
    import olink_pkg::*;
#(
    parameter oct_t IDLE = K28_5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic en,
    input  logic q_empty,
    input  oct_t q_head,
    output logic q_pop,
    output oct_t enc_data,
    output logic enc_ctrl
);
    // Pop only when enabled and a byte is waiting.
    always_comb q_pop = req && en && !q_empty;

    // Register the selected symbol at each request boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_data <= IDLE;
            enc_ctrl <= 1'b1;
        end else if (req) begin
            if (q_pop) begin
                enc_data <= q_head;
                enc_ctrl <= 1'b0;
            end else begin
                enc_data <= IDLE;
                enc_ctrl <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/olink_rx_filt.sv
// Receive filter: forwards decoded data bytes to the queue and tracks overflow.
// Assumes q_full reflects the queue state in the same cycle as the strobe.
module olink_rx_filt (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic is_ctrl,
    input  logic q_full,
    input  logic clr,
    output logic q_push,
    output logic ovf
);
    logic lost;

    // Data bytes only; control symbols are discarded.
    always_comb begin
        q_push = strobe && !is_ctrl;
        lost   = q_push && q_full;
    end

    // Sticky overflow; a loss in the same cycle beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf <= 1'b0;
        else if (lost) ovf <= 1'b1;
        else if (clr)  ovf <= 1'b0;
    end
endmodule

// File: rtl/olink_frame_ctrl.sv
// Optical link byte framing controller top: transmit queue plus scheduler,
// receive filter plus queue, level interrupt on receive non-empty.
// Assumes one byte per clock at the link coder side.
module olink_frame_ctrl
    import olink_pkg::*;
#(
    parameter int   TX_AW     = 4,
    parameter int   RX_AW     = 4,
    parameter oct_t IDLE_CODE = K28_5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_tx_wr,
    input  logic [7:0] cpu_tx_data,
    output logic       tx_full,
    input  logic       tx_en,
    input  logic       enc_rd_req,
    output logic [7:0] enc_data,
    output logic       enc_ctrl,
    input  logic       dec_strobe,
    input  logic [7:0] dec_data,
    input  logic       dec_ctrl,
    input  logic       cpu_rx_rd,
    output logic [7:0] cpu_rx_data,
    output logic       rx_irq,
    output logic       rx_ovf,
    input  logic       ovf_clr
);
    logic tx_empty, tx_pop;
    oct_t tx_head;
    logic rx_full, rx_empty, rx_push;

    olink_byte_fifo #(.W(BYTE_W), .AW(TX_AW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(cpu_tx_wr), .din(cpu_tx_data),
        .pop(tx_pop), .dout(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    olink_tx_sched #(.IDLE(IDLE_CODE)) u_sched (
        .clk(clk), .rst_n(rst_n),
        .req(enc_rd_req), .en(tx_en),
        .q_empty(tx_empty), .q_head(tx_head), .q_pop(tx_pop),
        .enc_data(enc_data), .enc_ctrl(enc_ctrl)
    );

    olink_rx_filt u_filt (
        .clk(clk), .rst_n(rst_n),
        .strobe(dec_strobe), .is_ctrl(dec_ctrl), .q_full(rx_full),
        .clr(ovf_clr), .q_push(rx_push), .ovf(rx_ovf)
    );

    olink_byte_fifo #(.W(BYTE_W), .AW(RX_AW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(dec_data),
        .pop(cpu_rx_rd), .dout(cpu_rx_data),
        .full(rx_full), .empty(rx_empty)
    );

    // Level interrupt while anything is waiting.
    always_comb rx_irq = !rx_empty;
endmodule

// File: rtl/olink_frame_chk.sv
// Property checker for olink_frame_ctrl, attached by bind.
module olink_frame_chk #(
    parameter logic [7:0] IDLE = 8'hBC
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enc_rd_req,
    input logic       tx_en,
    input logic [7:0] enc_data,
    input logic       enc_ctrl,
    input logic       dec_strobe,
    input logic       dec_ctrl,
    input logic       cpu_rx_rd,
    input logic       rx_irq,
    input logic       rx_ovf,
    input logic       ovf_clr
);
    // R5: no request, no change on the encoder side.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_rd_req |=> ($stable(enc_data) && $stable(enc_ctrl)));

    // R2: a request while disabled yields a control symbol.
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_rd_req && !tx_en) |=> enc_ctrl);

    // R4: a control symbol is always the idle code.
    a_r4_ctrl_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        enc_ctrl |-> (enc_data == IDLE));

    // R8: the interrupt only drops after a processor read.
    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq) |-> $past(cpu_rx_rd));

    // R7: a control strobe into an empty queue raises no interrupt.
    a_r7_ctrl_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_strobe && dec_ctrl && !rx_irq) |=> !rx_irq);

    // R9: overflow is sticky until cleared.
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !ovf_clr) |=> rx_ovf);
endmodule

bind olink_frame_ctrl olink_frame_chk #(.IDLE(IDLE_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .enc_rd_req(enc_rd_req), .tx_en(tx_en),
    .enc_data(enc_data), .enc_ctrl(enc_ctrl), .dec_strobe(dec_strobe),
    .dec_ctrl(dec_ctrl), .cpu_rx_rd(cpu_rx_rd), .rx_irq(rx_irq),
    .rx_ovf(rx_ovf), .ovf_clr(ovf_clr)
);

// File: tb/sim_olink_frame_ctrl.sv
module sim_olink_frame_ctrl;
    localparam int CLK_NS = 10;
    localparam int TXD = 8;
    localparam int RXD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_tx_wr = 1'b0;
    logic [7:0] cpu_tx_data = '0;
    logic       tx_full;
    logic       tx_en = 1'b0;
    logic       enc_rd_req = 1'b0;
    logic [7:0] enc_data;
    logic       enc_ctrl;
    logic       dec_strobe = 1'b0;
    logic [7:0] dec_data = '0;
    logic       dec_ctrl = 1'b0;
    logic       cpu_rx_rd = 1'b0;
    logic [7:0] cpu_rx_data;
    logic       rx_irq;
    logic       rx_ovf;
    logic       ovf_clr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    olink_frame_ctrl #(.TX_AW(3), .RX_AW(2)) u0 (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tx_write(input logic [7:0] b);
        cpu_tx_wr = 1'b1; cpu_tx_data = b; step(); cpu_tx_wr = 1'b0;
    endtask

    task automatic enc_pull(input logic [7:0] exp_d, input logic exp_c, input string req);
        enc_rd_req = 1'b1; step(); enc_rd_req = 1'b0;
        chk({23'd0, enc_ctrl, enc_data}, {23'd0, exp_c, exp_d}, req);
    endtask

    task automatic rx_feed(input logic [7:0] b, input logic c);
        dec_strobe = 1'b1; dec_data = b; dec_ctrl = c; step();
        dec_strobe = 1'b0; dec_ctrl = 1'b0;
    endtask

    task automatic rx_take(input logic [7:0] exp, input string req);
        chk({24'd0, cpu_rx_data}, {24'd0, exp}, req);
        cpu_rx_rd = 1'b1; step(); cpu_rx_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk({28'd0, enc_ctrl, rx_irq, rx_ovf, tx_full}, 32'h8, "R1 flags");
        chk({24'd0, enc_data}, 32'hBC, "R1 enc_data");
    endtask

    task automatic t_disabled();
        tx_write(8'hA1); tx_write(8'hA2); tx_write(8'hA3);
        enc_pull(8'hBC, 1'b1, "R2 idle while off");
        enc_pull(8'hBC, 1'b1, "R2 idle while off again");
        step(); step(); step();
        chk({23'd0, enc_ctrl, enc_data}, {23'd0, 1'b1, 8'hBC}, "R5 hold");
    endtask

    task automatic t_send();
        tx_en = 1'b1;
        enc_pull(8'hA1, 1'b0, "R3 first byte");
        step(); step();
        chk({23'd0, enc_ctrl, enc_data}, {23'd0, 1'b0, 8'hA1}, "R5 hold payload");
        enc_pull(8'hA2, 1'b0, "R3 second byte");
        tx_en = 1'b0;
        enc_pull(8'hBC, 1'b1, "R6 stop at boundary");
        tx_en = 1'b1;
        enc_pull(8'hA3, 1'b0, "R6 resume");
        enc_pull(8'hBC, 1'b1, "R4 empty idle");
        tx_en = 1'b0;
    endtask

    task automatic t_tx_full();
        for (int i = 0; i < TXD; i++) tx_write(8'h10 + 8'(i));
        chk({31'd0, tx_full}, 32'd1, "R10 full flag");
        tx_write(8'hFF);
        tx_en = 1'b1;
        for (int i = 0; i < TXD; i++) enc_pull(8'h10 + 8'(i), 1'b0, "R10 kept byte");
        enc_pull(8'hBC, 1'b1, "R10 extra write ignored");
        chk({31'd0, tx_full}, 32'd0, "R10 full cleared");
        tx_en = 1'b0;
    endtask

    task automatic t_rx();
        rx_feed(8'hBC, 1'b1);
        chk({31'd0, rx_irq}, 32'd0, "R7 control discarded");
        rx_feed(8'h55, 1'b0);
        chk({31'd0, rx_irq}, 32'd1, "R8 irq rises");
        rx_feed(8'hBC, 1'b1);
        rx_feed(8'h66, 1'b0);
        rx_take(8'h55, "R7 data written");
        rx_take(8'h66, "R11 order, control skipped");
        chk({31'd0, rx_irq}, 32'd0, "R8 irq falls");
        cpu_rx_rd = 1'b1; step(); cpu_rx_rd = 1'b0;
        chk({31'd0, rx_irq}, 32'd0, "R11 empty read");
        rx_feed(8'h77, 1'b0);
        rx_take(8'h77, "R11 after empty read");
        chk({31'd0, rx_irq}, 32'd0, "R8 drained");
    endtask

    task automatic t_ovf();
        for (int i = 0; i < RXD; i++) rx_feed(8'h20 + 8'(i), 1'b0);
        chk({31'd0, rx_ovf}, 32'd0, "R9 no overflow at full");
        rx_feed(8'h24, 1'b0);
        chk({31'd0, rx_ovf}, 32'd1, "R9 overflow set");
        for (int i = 0; i < RXD; i++) rx_take(8'h20 + 8'(i), "R9 dropped byte absent");
        chk({30'd0, rx_irq, rx_ovf}, 32'd1, "R9 sticky, queue empty");
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        chk({31'd0, rx_ovf}, 32'd0, "R9 cleared");
        for (int i = 0; i < RXD; i++) rx_feed(8'h30 + 8'(i), 1'b0);
        ovf_clr = 1'b1; rx_feed(8'h99, 1'b0); ovf_clr = 1'b0;
        chk({31'd0, rx_ovf}, 32'd1, "R9 set beats clear");
        for (int i = 0; i < RXD; i++) rx_take(8'h30 + 8'(i), "R9 drain");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_disabled();
        t_send();
        t_tx_full();
        t_rx();
        t_ovf();
        finish_run();
    end

    initial begin
        #(CLK_NS * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end
endmodule